// File: doc/BRIEF.md
# Vector Table Byte Lookup

This block carries out the byte gather behind a vector table-permute operation. A 64-bit index word carries eight 8-bit indices, one for each byte of the 64-bit result. The table is made of one to four 128-bit vector registers, starting at a chosen register number in a 32-entry register file. Register numbers past 31 wrap back to register 0.

A caller pulses `start_i` with the index word, an initial result word, the first register number and the register count. The block then reads the table registers one per cycle through a read port whose data returns one cycle later. As each register arrives, every result byte whose index points into that register takes the addressed byte. A byte whose index lies past the end of the table keeps its value from the initial word. A caller that passes zeros gets the zeroing form of the instruction. A caller that passes the old destination gets the merging form. The result is presented with a one-cycle `done_o` strobe.

The controller is a four-state machine. IDLE waits for a start. ISSUE drives one register read per cycle. DRAIN waits for the last read data. DONE raises the strobe. The transitions are:
- IDLE→ISSUE on an accepted start.
- ISSUE→ISSUE while reads remain.
- ISSUE→DRAIN after the last read is issued.
- DRAIN→DONE when the last data has been merged.
- DONE→IDLE unconditionally.

Top module: `vtbl_lookup`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `rd_en_o` are 0 and `result_o` is 0.
- R2: Result byte k (bits [8k+7:8k]) is driven by index byte k (bits [8k+7:8k] of `idx_i`). An in-range index i selects register (`base_i` + i/16) mod 32 and byte i mod 16 of it, where byte b of a register is bits [8b+7:8b].
- R3: Index i is in range only if i < 16·`cnt_i`. An out-of-range index leaves result byte k equal to byte k of `init_i`, with both zero and nonzero initial words.
- R4: Table register numbers wrap modulo 32, so base 30 with count 4 reads registers 30, 31, 0 and 1.
- R5: After a start, `rd_en_o` is high for exactly `cnt_i` consecutive cycles, beginning the cycle after the start. `rd_addr_o` starts at `base_i` and increases by one each cycle, modulo 32.
- R6: `done_o` is a one-cycle pulse, two cycles after the last `rd_en_o` cycle, which is one cycle after the last read data returns. `result_o` is valid while `done_o` is high and holds its value until the next accepted start.
- R7: `start_i` is ignored while `busy_o` is high. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle.
- R8: Counts 1 to 4 are supported, and `cnt_i` must be in that range on an accepted start. With count 4, index 63 is in range and index 64 is not. With count 2, index 31 is in range and index 32 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a lookup (taken only when idle) |
| idx_i | input | 64 | Eight byte indices |
| init_i | input | 64 | Initial result word |
| base_i | input | 5 | First table register number |
| cnt_i | input | 3 | Number of table registers, 1 to 4 |
| rd_en_o | output | 1 | Register file read request |
| rd_addr_o | output | 5 | Register number to read |
| rd_data_i | input | 128 | Read data, valid the cycle after a request |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | Result valid strobe |
| result_o | output | 64 | Lookup result |

## Verification
The bench builds the block with its default parameters: a 32-entry file of 16-byte registers, up to 4 table registers and 8 result lanes. With these values a base near the top of the file crosses the wrap from register 31 to register 0. Every in-range index value from 0 to 63 can also be reached. The range limits sit at the byte indices 16, 32, 48 and 64, and the directed indices are placed on both sides of each limit. Register contents follow a pattern that differs per register and per byte, so a wrong register or a wrong byte gives a visible mismatch.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } vtbl_state_e;
endpackage

// File: rtl/vtbl_fsm.sv
module vtbl_fsm
    import vtbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_issue_i,
    output logic accept_o,
    output logic issue_o,
    output logic busy_o,
    output logic done_o
);
    vtbl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        issue_o  = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                busy_o  = 1'b1;
                issue_o = 1'b1;
                if (last_issue_i) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                busy_o  = 1'b1;
                state_d = ST_DONE;
            end
            ST_DONE: begin
                busy_o  = 1'b1;
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_issue_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> issue_o);
endmodule

// File: rtl/vtbl_addr_gen.sv
module vtbl_addr_gen #(
    parameter int NREGS   = 32,
    parameter int MAX_TBL = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept_i,
    input  logic                         issue_i,
    input  logic [$clog2(NREGS)-1:0]     base_i,
    input  logic [$clog2(MAX_TBL+1)-1:0] cnt_i,
    output logic                         rd_en_o,
    output logic [$clog2(NREGS)-1:0]     rd_addr_o,
    output logic                         last_issue_o,
    output logic                         ret_valid_o,
    output logic [$clog2(MAX_TBL)-1:0]   ret_k_o,
    output logic [$clog2(MAX_TBL+1)-1:0] cnt_o
);
    localparam int REG_W = $clog2(NREGS);
    localparam int CNT_W = $clog2(MAX_TBL + 1);
    localparam int K_W   = $clog2(MAX_TBL);

    logic [REG_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [K_W-1:0]   k_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            cnt_q       <= CNT_W'(1);
            k_q         <= '0;
            ret_valid_o <= 1'b0;
            ret_k_o     <= '0;
        end else begin
            ret_valid_o <= issue_i;
            ret_k_o     <= k_q;
            if (accept_i) begin
                base_q <= base_i;
                cnt_q  <= cnt_i;
                k_q    <= '0;
            end else if (issue_i) begin
                k_q <= k_q + K_W'(1);
            end
        end
    end

    assign rd_en_o      = issue_i;
    assign rd_addr_o    = base_q + REG_W'(k_q);
    assign last_issue_o = ({{(CNT_W-K_W){1'b0}}, k_q} == (cnt_q - CNT_W'(1)));
    assign cnt_o        = cnt_q;

    // R4 / R5: consecutive reads step by one register, wrapping at the file size
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == REG_W'($past(rd_addr_o) + REG_W'(1))));

    assert_cnt_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> (cnt_i != '0 && int'(cnt_i) <= MAX_TBL));
endmodule

// File: rtl/vtbl_byte_merge.sv
module vtbl_byte_merge #(
    parameter int LANES     = 8,
    parameter int REG_BYTES = 16,
    parameter int MAX_TBL   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [LANES*8-1:0]           idx_i,
    input  logic [LANES*8-1:0]           init_i,
    input  logic [$clog2(MAX_TBL+1)-1:0] cnt_i,
    input  logic                         ret_valid_i,
    input  logic [$clog2(MAX_TBL)-1:0]   ret_k_i,
    input  logic [REG_BYTES*8-1:0]       ret_data_i,
    output logic [LANES*8-1:0]           result_o
);
    localparam int BSEL_W = $clog2(REG_BYTES);

    logic [LANES*8-1:0] idx_q;
    logic [LANES*8-1:0] res_q;
    logic [LANES*8-1:0] res_d;
    logic [LANES-1:0]   in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            res_q <= '0;
        end else if (load_i) begin
            idx_q <= idx_i;
            res_q <= init_i;
        end else begin
            res_q <= res_d;
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [7:0]        lane_idx;
        logic [BSEL_W-1:0] bsel;
        logic              hit;

        assign lane_idx    = idx_q[8*j +: 8];
        assign bsel        = lane_idx[BSEL_W-1:0];
        assign in_range[j] = 32'(lane_idx) < (32'(cnt_i) * 32'(REG_BYTES));
        assign hit         = ret_valid_i && in_range[j] &&
                             (32'(lane_idx >> BSEL_W) == 32'(ret_k_i));
        assign res_d[8*j +: 8] = hit ? ret_data_i[{bsel, 3'b000} +: 8] : res_q[8*j +: 8];

        // R3: a lane whose index is past the table never leaves its initial value
        assert_oor_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_i && !in_range[j]) |=> $stable(res_q[8*j +: 8]));
    end

    assign result_o = res_q;
endmodule

// File: rtl/vtbl_lookup.sv
module vtbl_lookup #(
    parameter int NREGS     = 32,
    parameter int REG_BYTES = 16,
    parameter int MAX_TBL   = 4,
    parameter int LANES     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [LANES*8-1:0]           idx_i,
    input  logic [LANES*8-1:0]           init_i,
    input  logic [$clog2(NREGS)-1:0]     base_i,
    input  logic [$clog2(MAX_TBL+1)-1:0] cnt_i,
    output logic                         rd_en_o,
    output logic [$clog2(NREGS)-1:0]     rd_addr_o,
    input  logic [REG_BYTES*8-1:0]       rd_data_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [LANES*8-1:0]           result_o
);
    localparam int CNT_W = $clog2(MAX_TBL + 1);
    localparam int K_W   = $clog2(MAX_TBL);

    logic             accept, issue, last_issue, ret_valid;
    logic [K_W-1:0]   ret_k;
    logic [CNT_W-1:0] cnt_q;

    vtbl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .last_issue_i (last_issue),
        .accept_o     (accept),
        .issue_o      (issue),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    vtbl_addr_gen #(.NREGS(NREGS), .MAX_TBL(MAX_TBL)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .issue_i      (issue),
        .base_i       (base_i),
        .cnt_i        (cnt_i),
        .rd_en_o      (rd_en_o),
        .rd_addr_o    (rd_addr_o),
        .last_issue_o (last_issue),
        .ret_valid_o  (ret_valid),
        .ret_k_o      (ret_k),
        .cnt_o        (cnt_q)
    );

    vtbl_byte_merge #(.LANES(LANES), .REG_BYTES(REG_BYTES), .MAX_TBL(MAX_TBL)) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .idx_i        (idx_i),
        .init_i       (init_i),
        .cnt_i        (cnt_q),
        .ret_valid_i  (ret_valid),
        .ret_k_i      (ret_k),
        .ret_data_i   (rd_data_i),
        .result_o     (result_o)
    );

    assert_done_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(ret_valid) && !ret_valid && !rd_en_o));

    assert_no_read_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_en_o);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/vtbl_lookup_bench.sv
module vtbl_lookup_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [63:0]  idx_i = '0;
    logic [63:0]  init_i = '0;
    logic [4:0]   base_i = '0;
    logic [2:0]   cnt_i = 3'd1;
    logic         rd_en_o;
    logic [4:0]   rd_addr_o;
    logic [127:0] rd_data_i = '0;
    logic         busy_o, done_o;
    logic [63:0]  result_o;

    int checks = 0;
    int errors = 0;
    logic [127:0] rf [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    vtbl_lookup u_vtbl_lookup (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_i(idx_i), .init_i(init_i),
        .base_i(base_i), .cnt_i(cnt_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always @(posedge clk) if (rd_en_o) rd_data_i <= rf[rd_addr_o];

    function automatic logic [7:0] pat(int r, int b);
        return 8'((r * 37 + b * 3 + 5) & 255);
    endfunction

    function automatic logic [63:0] model(logic [63:0] idx, logic [63:0] init,
                                          int base, int cnt);
        logic [63:0] res = init;
        for (int l = 0; l < 8; l++) begin
            int i = int'(idx[8*l +: 8]);
            if (i < 16 * cnt) res[8*l +: 8] = pat((base + i / 16) % 32, i % 16);
        end
        return res;
    endfunction

    task automatic chk(logic ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One lookup; optional extra starts while busy (R7)
    task automatic run_op(logic [63:0] idx, logic [63:0] init, int base, int cnt,
                          bit poke, string req);
        logic [63:0] exp = model(idx, init, base, cnt);
        int cyc = 0, reads = 0, done_cyc = 0;
        bit addr_ok = 1;
        @(negedge clk);
        idx_i = idx; init_i = init; base_i = 5'(base); cnt_i = 3'(cnt); start_i = 1'b1;
        while (done_cyc == 0 && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (rd_en_o) begin
                if (int'(rd_addr_o) != (base + reads) % 32) addr_ok = 0;
                reads++;
            end
            if (done_o) done_cyc = cyc;
            if (poke && cyc <= 3) begin
                start_i = 1'b1; base_i = 5'(base + 7); cnt_i = 3'd1;
                idx_i = ~idx; init_i = ~init;
            end else begin
                start_i = 1'b0;
            end
        end
        chk(addr_ok, {req, " R5 read order"}, 64'(rd_addr_o), 64'(base));
        chk(reads == cnt, {req, " R5 read count"}, 64'(reads), 64'(cnt));
        chk(done_cyc == cnt + 2, {req, " R6 done timing"}, 64'(done_cyc), 64'(cnt + 2));
        chk(result_o == exp, {req, " result"}, result_o, exp);
        chk(busy_o == 1'b1, {req, " R7 busy in done cycle"}, 64'(busy_o), 64'd1);
        @(negedge clk);
        @(negedge clk);
        chk(!done_o && !busy_o && result_o == exp, {req, " R6 hold after done"},
            result_o, exp);
    endtask

    task automatic t_reset;
        #1;
        chk(!done_o && !busy_o && !rd_en_o && result_o == 64'd0, "R1 reset outputs",
            {61'd0, done_o, busy_o, rd_en_o}, 64'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !busy_o && !rd_en_o, "R1 idle after reset",
            {61'd0, done_o, busy_o, rd_en_o}, 64'd0);
    endtask

    task automatic t_single;   // R2 lanes, R3 out of range with zero init
        run_op(64'hFF10_0F00_0102_0304, 64'd0, 3, 1, 0, "R2 single reg");
    endtask

    task automatic t_four;     // R8 boundary 63/64
        run_op(64'h3F40_3011_2F20_1F10, 64'd0, 5, 4, 0, "R8 four regs");
    endtask

    task automatic t_two;      // R8 boundary 31/32
        run_op(64'h1F20_0010_0F1E_2122, 64'hAAAA_AAAA_AAAA_AAAA, 12, 2, 0, "R8 two regs");
    endtask

    task automatic t_three;
        run_op(64'h2F30_2021_0012_1E2E, 64'h0123_4567_89AB_CDEF, 20, 3, 0, "R2 three regs");
    endtask

    task automatic t_wrap;
        run_op(64'h3F30_2F20_1F10_0F00, 64'd0, 30, 4, 0, "R4 wrap");
        run_op(64'h1F10_0F00_1F10_0F00, 64'd0, 31, 2, 0, "R4 wrap edge");
    endtask

    task automatic t_merge;
        run_op(64'hFFC0_8070_6050_4130, 64'hDEAD_BEEF_CAFE_F00D, 9, 3, 0, "R3 merge all out");
        run_op(64'h0005_FF0A_8001_EE02, 64'h1122_3344_5566_7788, 0, 1, 0, "R3 merge mixed");
    endtask

    task automatic t_ignore;
        run_op(64'h0102_0304_1112_1314, 64'd0, 17, 2, 1, "R7 start ignored");
    endtask

    initial begin
        for (int r = 0; r < 32; r++)
            for (int b = 0; b < 16; b++) rf[r][8*b +: 8] = pat(r, b);
        t_reset();
        t_single();
        t_four();
        t_two();
        t_three();
        t_wrap();
        t_merge();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule